// File: doc/BRIEF.md
# Extended Reach Mode Sequencer

This controller sits on the host side of a serial-video cable equaliser and decides when the equaliser should run in its extended-reach equalisation mode and when it should return to normal mode. It reaches the equaliser only through a simple register port. The port has a request with a read/write flag, an 8-bit address and 8-bit write data. The responder returns read data together with a one-cycle done pulse. The transport that carries these accesses lies outside the block.

While idle, the sequencer reads the general control register (address 00h) once every `POLL_CYCLES` clocks. In normal mode with carrier present, it also reads the cable-length register (address 03h). The poll result decides whether a mode change is needed. A mode change always follows the same four steps: force the equaliser to sleep, flip the mode bit, hold for at least one millisecond, then release the sleep field. Every write to the control register keeps the mute and bypass settings read in the poll. The code threshold, the poll interval and the hold time are parameters, and each is checked when the block is elaborated.

Top module: `ext_reach_seq`

## Requirements
- R1: After reset, `mode_ext` is 0 (normal), `busy` is 0 and `req_valid` is 0.
- R2: While idle, a read of address 00h is issued every `POLL_CYCLES` clocks. A raised request keeps `req_write`, `req_addr` and `req_wdata` unchanged until the cycle in which `rsp_done` is high.
- R3: In normal mode, a poll that returns bit 7 of 00h (carrier) as 0 ends the poll. No read of 03h and no write follows, and the mode stays normal.
- R4: In normal mode with carrier present, the code in bits 7:3 of 03h is compared with `CODE_THRESH`. A code equal to or above the threshold leaves the block in normal mode with no write.
- R5: A code strictly below the threshold starts entry. The block writes 00h with the sleep field (bits 4:3) set to 10 and the mode bit (bit 2) at its old value. It then writes 00h with sleep 10 and bit 2 = 1. It waits at least `WAIT_CYCLES` clocks and then writes the release value. `mode_ext` becomes 1 when that last write completes.
- R6: In extended mode, a poll that returns carrier 0 starts exit. The block writes sleep 10 with bit 2 still 1, then sleep 10 with bit 2 = 0, waits, and writes the release value. `mode_ext` returns to 0 when that last write completes.
- R7: Every write to 00h copies bits 6:5 (mute, bypass) from the most recent poll of 00h and writes bits 1:0 and bit 7 as 0.
- R8: `busy` is high from the first sequence write until the release write completes. No read is issued while `busy` is high.
- R9: In extended mode with carrier present, a poll consists of the 00h read alone, with no 03h read and no write.
- R10: The release value of the sleep field is 01 (automatic sleep) when `cfg_sleep_off` is 0 and 00 (sleep disabled) when it is 1. The value 11 is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sleep_off | input | 1 | Selects sleep-disabled (1) instead of automatic sleep (0) as the release value |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 8 | Write data (0 on reads) |
| rsp_rdata | input | 8 | Read data, valid when rsp_done is high |
| rsp_done | input | 1 | One-cycle completion of the pending request |
| mode_ext | output | 1 | 1 = equaliser is in extended-reach mode |
| busy | output | 1 | A mode-switch sequence is in progress |

## Verification
The assertions check the rules that hold in every cycle. A pending request stays stable until done, and bits 1:0 of control writes are 0. The sleep field is never 11, and no read occurs while busy. They also check that the release write comes at least `WAIT_CYCLES` after the write before it, and that the mode flag changes only when a sequence completes. The bench scenarios cover the decisions the block takes from read data: no carrier, a code equal to or above the threshold, a code below it, a carrier drop in extended mode, and both release choices. In these scenarios the bench compares the exact order, addresses and data of the accesses, including the mute and bypass bits carried through each write.

// File: rtl/ext_reach_pkg.sv
package ext_reach_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_CTRL,
      ST_RD_LEN,
      ST_WR_SLEEP,
      ST_WR_MODE,
      ST_HOLD,
      ST_WR_WAKE
   } seq_state_t;

   localparam logic [1:0] SLP_OFF   = 2'b00;
   localparam logic [1:0] SLP_AUTO  = 2'b01;
   localparam logic [1:0] SLP_FORCE = 2'b10;

   // Control word: bit7 zero, 6:5 kept mute/bypass, 4:3 sleep, 2 mode, 1:0 zero
   function automatic logic [7:0] ctrl_word(input logic [1:0] keep,
                                            input logic [1:0] slp,
                                            input logic       ext);
      return {1'b0, keep, slp, ext, 2'b00};
   endfunction

endpackage

// File: rtl/seq_interval.sv
module seq_interval #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic hit
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT <= 1) begin : g_trivial
         assign hit = run;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign hit = run && (cnt == CW'(LIMIT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt <= '0;
            else if (!run)    cnt <= '0;
            else if (hit)     cnt <= '0;
            else              cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ext_reach_seq.sv
module ext_reach_seq
   import ext_reach_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 100_000_000,
   parameter int unsigned WAIT_CYCLES = 100_000,
   parameter int unsigned POLL_CYCLES = 4096,
   parameter logic [4:0]  CODE_THRESH = 5'b10010,
   parameter logic [7:0]  CTRL_ADDR   = 8'h00,
   parameter logic [7:0]  LEN_ADDR    = 8'h03
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_sleep_off,
   output logic       req_valid,
   output logic       req_write,
   output logic [7:0] req_addr,
   output logic [7:0] req_wdata,
   input  logic [7:0] rsp_rdata,
   input  logic       rsp_done,
   output logic       mode_ext,
   output logic       busy
);
   localparam int unsigned MIN_WAIT = CLK_HZ / 1000;

   generate
      if (WAIT_CYCLES < MIN_WAIT || WAIT_CYCLES == 0) begin : g_bad_wait
         $error("WAIT_CYCLES shorter than one millisecond of clk");
      end
      if (POLL_CYCLES == 0) begin : g_bad_poll
         $error("POLL_CYCLES must be at least 1");
      end
   endgenerate

   seq_state_t state;
   logic [1:0] keep_q;
   logic       target_q;
   logic       poll_hit;
   logic       hold_hit;
   logic       carrier;
   logic [4:0] len_code;
   logic [1:0] wake_slp;

   seq_interval #(.LIMIT(POLL_CYCLES)) i_poll (
      .clk(clk), .rst_n(rst_n), .run(state == ST_IDLE), .hit(poll_hit));

   seq_interval #(.LIMIT(WAIT_CYCLES)) i_hold (
      .clk(clk), .rst_n(rst_n), .run(state == ST_HOLD), .hit(hold_hit));

   assign carrier  = rsp_rdata[7];
   assign len_code = rsp_rdata[7:3];
   assign wake_slp = cfg_sleep_off ? SLP_OFF : SLP_AUTO;

   always_comb begin
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = CTRL_ADDR;
      req_wdata = 8'h00;
      busy      = 1'b0;
      unique case (state)
         ST_IDLE: ;
         ST_RD_CTRL: req_valid = 1'b1;
         ST_RD_LEN: begin
            req_valid = 1'b1;
            req_addr  = LEN_ADDR;
         end
         ST_WR_SLEEP: begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_wdata = ctrl_word(keep_q, SLP_FORCE, mode_ext);
            busy      = 1'b1;
         end
         ST_WR_MODE: begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_wdata = ctrl_word(keep_q, SLP_FORCE, target_q);
            busy      = 1'b1;
         end
         ST_HOLD: busy = 1'b1;
         ST_WR_WAKE: begin
            req_valid = 1'b1;
            req_write = 1'b1;
            req_wdata = ctrl_word(keep_q, wake_slp, target_q);
            busy      = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         keep_q   <= 2'b00;
         target_q <= 1'b0;
         mode_ext <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE:
               if (poll_hit) state <= ST_RD_CTRL;
            ST_RD_CTRL:
               if (rsp_done) begin
                  keep_q <= rsp_rdata[6:5];
                  if (mode_ext) begin
                     if (!carrier) begin
                        target_q <= 1'b0;
                        state    <= ST_WR_SLEEP;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     state <= carrier ? ST_RD_LEN : ST_IDLE;
                  end
               end
            ST_RD_LEN:
               if (rsp_done) begin
                  if (len_code < CODE_THRESH) begin
                     target_q <= 1'b1;
                     state    <= ST_WR_SLEEP;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            ST_WR_SLEEP:
               if (rsp_done) state <= ST_WR_MODE;
            ST_WR_MODE:
               if (rsp_done) state <= ST_HOLD;
            ST_HOLD:
               if (hold_hit) state <= ST_WR_WAKE;
            ST_WR_WAKE:
               if (rsp_done) begin
                  mode_ext <= target_q;
                  state    <= ST_IDLE;
               end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ext_reach_seq_chk.sv
module ext_reach_seq_chk #(
   parameter int unsigned WAIT_CYCLES = 100_000,
   parameter logic [7:0]  CTRL_ADDR   = 8'h00
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_write,
   input logic [7:0] req_addr,
   input logic [7:0] req_wdata,
   input logic       rsp_done,
   input logic       mode_ext,
   input logic       busy
);
   logic [31:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            gap <= '0;
      else if (req_valid && req_write && rsp_done) gap <= '0;
      else if (gap != 32'hFFFF_FFFF)         gap <= gap + 1'b1;
   end

   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !rsp_done |=> req_valid && $stable(req_write)
                                && $stable(req_addr) && $stable(req_wdata));

   a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && req_addr == CTRL_ADDR |-> req_wdata[1:0] == 2'b00);

   a_r10_no_reserved_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write |-> req_wdata[4:3] != 2'b11);

   a_r8_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && req_valid |-> req_write);

   a_r8_busy_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(rsp_done) && !$past(req_write));

   a_r5_hold_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) && req_write && req_wdata[4:3] != 2'b10 |-> gap >= WAIT_CYCLES);

   a_r6_mode_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ext != $past(mode_ext) |-> $past(busy) && !busy && $past(rsp_done));
endmodule

bind ext_reach_seq ext_reach_seq_chk #(
   .WAIT_CYCLES(WAIT_CYCLES),
   .CTRL_ADDR(CTRL_ADDR)
) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
   .mode_ext(mode_ext), .busy(busy));

// File: tb/test_ext_reach_seq.sv
module test_ext_reach_seq;
   localparam int CLK_PERIOD = 10;
   localparam int WAIT_C     = 20;
   localparam int POLL_C     = 16;
   localparam int WATCHDOG   = 20000;

   typedef struct {
      logic       wr;
      logic [7:0] addr;
      logic [7:0] data;
      string      req;
   } txn_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_sleep_off = 1'b0;
   logic       req_valid, req_write;
   logic [7:0] req_addr, req_wdata;
   logic [7:0] rsp_rdata = 8'h00;
   logic       rsp_done = 1'b0;
   logic       mode_ext, busy;

   txn_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   cyc = 0;
   int   last_wr_cyc = 0;
   int   lat = 0;
   bit   timed_out = 0;

   // register model of the equaliser
   logic       m_carrier = 1'b0;
   logic [6:0] m_ctrl = 7'b10_01_0_00;
   logic [4:0] m_code = 5'd0;

   ext_reach_seq #(
      .CLK_HZ(20000), .WAIT_CYCLES(WAIT_C), .POLL_CYCLES(POLL_C),
      .CODE_THRESH(5'b10010)
   ) i_ext_reach_seq (
      .clk(clk), .rst_n(rst_n), .cfg_sleep_off(cfg_sleep_off),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .mode_ext(mode_ext), .busy(busy));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic push(input logic wr, input logic [7:0] addr,
                       input logic [7:0] data, input string req);
      txn_t t;
      t.wr = wr; t.addr = addr; t.data = data; t.req = req;
      exp_q.push_back(t);
   endtask

   task automatic drain();
      while (exp_q.size() != 0 && !timed_out) begin
         @(negedge clk);
         if (cyc > WATCHDOG) begin
            timed_out = 1;
            check(0, "WDOG", "watchdog expired", cyc, WATCHDOG);
         end
      end
      repeat (3) @(negedge clk);
   endtask

   // responder + scoreboard monitor, runs away from the active edge
   always @(negedge clk) begin
      if (rsp_done) begin
         rsp_done = 1'b0;
         lat = 0;
      end else if (req_valid) begin
         lat++;
         if (lat == 2) begin
            if (exp_q.size() == 0) begin
               check(0, "R2", "unexpected access addr", int'(req_addr), -1);
            end else begin
               txn_t e;
               e = exp_q.pop_front();
               check(req_write == e.wr, e.req, "access kind", int'(req_write), int'(e.wr));
               check(req_addr == e.addr, e.req, "access addr", int'(req_addr), int'(e.addr));
               if (e.wr) begin
                  check(req_wdata == e.data, e.req, "write data", int'(req_wdata), int'(e.data));
                  check(busy == 1'b1, "R8", "busy during write", int'(busy), 1);
                  if (req_wdata[4:3] != 2'b10)
                     check(cyc - last_wr_cyc >= WAIT_C, "R5", "hold length",
                           cyc - last_wr_cyc, WAIT_C);
               end
            end
            if (req_write) begin
               if (req_addr == 8'h00) m_ctrl = req_wdata[6:0];
               last_wr_cyc = cyc;
            end else begin
               rsp_rdata = (req_addr == 8'h03) ? {m_code, 3'b000} : {m_carrier, m_ctrl};
            end
            rsp_done = 1'b1;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(mode_ext == 1'b0, "R1", "mode after reset", int'(mode_ext), 0);
      check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      check(req_valid == 1'b0, "R1", "request after reset", int'(req_valid), 0);
      rst_n = 1'b1;

      // R3: no carrier, only 00h polls
      push(0, 8'h00, 8'h00, "R3");
      push(0, 8'h00, 8'h00, "R3");
      drain();
      check(mode_ext == 1'b0, "R3", "mode without carrier", int'(mode_ext), 0);

      // R4: code equal to threshold, then above
      m_carrier = 1'b1; m_code = 5'd18;
      push(0, 8'h00, 8'h00, "R4"); push(0, 8'h03, 8'h00, "R4");
      drain();
      m_code = 5'd25;
      push(0, 8'h00, 8'h00, "R4"); push(0, 8'h03, 8'h00, "R4");
      drain();
      check(mode_ext == 1'b0, "R4", "mode at long cable", int'(mode_ext), 0);

      // R5 / R7: entry, mute kept (bits 6:5 = 10), auto release
      m_code = 5'd17;
      push(0, 8'h00, 8'h00, "R5"); push(0, 8'h03, 8'h00, "R5");
      push(1, 8'h00, 8'h50, "R7"); push(1, 8'h00, 8'h54, "R5");
      push(1, 8'h00, 8'h4C, "R5");
      drain();
      check(mode_ext == 1'b1, "R5", "mode after entry", int'(mode_ext), 1);
      check(busy == 1'b0, "R8", "busy after entry", int'(busy), 0);

      // R9: extended mode with carrier, only 00h polls
      m_code = 5'd2;
      push(0, 8'h00, 8'h00, "R9"); push(0, 8'h00, 8'h00, "R9");
      drain();
      check(mode_ext == 1'b1, "R9", "mode kept", int'(mode_ext), 1);

      // R6: carrier drop
      m_carrier = 1'b0;
      push(0, 8'h00, 8'h00, "R6");
      push(1, 8'h00, 8'h54, "R6"); push(1, 8'h00, 8'h50, "R6");
      push(1, 8'h00, 8'h48, "R6");
      drain();
      check(mode_ext == 1'b0, "R6", "mode after exit", int'(mode_ext), 0);

      // R10 / R7: sleep-off release, bypass kept (bits 6:5 = 01)
      cfg_sleep_off = 1'b1;
      m_ctrl = 7'b01_01_0_00;
      m_carrier = 1'b1; m_code = 5'd0;
      push(0, 8'h00, 8'h00, "R10"); push(0, 8'h03, 8'h00, "R10");
      push(1, 8'h00, 8'h30, "R7"); push(1, 8'h00, 8'h34, "R10");
      push(1, 8'h00, 8'h24, "R10");
      drain();
      check(mode_ext == 1'b1, "R10", "mode after entry", int'(mode_ext), 1);
      m_carrier = 1'b0;
      push(0, 8'h00, 8'h00, "R10");
      push(1, 8'h00, 8'h34, "R10"); push(1, 8'h00, 8'h30, "R10");
      push(1, 8'h00, 8'h20, "R10");
      drain();
      check(mode_ext == 1'b0, "R10", "mode after exit", int'(mode_ext), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule